// File: doc/BRIEF.md
# SD Card SPI-Mode Power-Up Sequencer

This block takes a freshly powered memory card through its SPI-mode start-up with no help from software. It first clocks a run of idle bytes with chip select released. It then selects the card and steps through reset, interface-condition check, the operating-condition loop and an OCR read. From the answers it works out whether the card is an SD v2, an SD v1 or an MMC device, and whether it addresses by block (high capacity).

The sequencer drives its own SPI byte shifter in mode 0. The serial clock is divided down from the system clock by `CLK_DIV`, which is chosen so that the initialization rate falls inside 100 to 400 kHz. Card timing quirks are absorbed in three ways:
- A response is searched for over a bounded number of bytes.
- Before each new command, idle bytes are sent until the card answers 0xFF.
- An illegal-command answer drops the sequence to the next older card family.

A `start` pulse launches or relaunches the sequence. `retry_max` bounds the number of operating-condition attempts. The block has no data stream: every port is a plain control or status level, so no back-pressure rules apply. Results hold until the next `start` or reset.

Top module: `sd_spi_init`

## Requirements
- R1: After `start`, at least 80 SCLK cycles (`WAKE_BYTES`×8) are issued with `spi_cs_n` high and MOSI held at 1. `spi_cs_n` then goes low and stays low until the next `start` or reset.
- R2: The first command frame is 40 00 00 00 00 95. An R1 of 0x01 (idle) lets the sequence continue.
- R3: After each frame the block clocks out up to `POLL_MAX` (8) bytes and takes the first byte with bit 7 = 0 as R1. If none of them qualifies, `init_error` is raised.
- R4: Before each command frame, 0xFF bytes are clocked until the card returns 0xFF, with at least one such byte. A frame never starts while the card is still sending non-0xFF bytes.
- R5: The interface-condition frame is 48 00 00 01 AA 87. If R1 bit 2 (illegal command) is clear, four more bytes are read. If their low 12 bits are not 0x1AA, `init_error` is raised; otherwise the card is SD v2.
- R6: If R1 bit 2 is set on the interface-condition frame, the card is handled as SD v1. The operating-condition request is then 77 00 00 00 00 65 followed by 69 00 10 00 00 5F, or by 69 40 10 00 00 CD for SD v2.
- R7: If R1 bit 2 is set on the 69 frame, the card is taken as MMC and the request becomes 41 00 00 00 00 F9.
- R8: The operating-condition request is repeated while R1 = 0x01. If attempt number `retry_max` still returns 0x01, `init_error` is raised. For MMC the attempt count restarts at the switch.
- R9: Once R1 = 0x00, the frame 7A 00 00 00 00 FD is sent and four bytes are read into `ocr`. `high_cap` equals OCR bit 30 for SD v2 cards and is 0 for other types.
- R10: `card_type` encoding: 0 none, 1 MMC, 2 SD v1, 3 SD v2. `init_done` and `init_error` are never high together, and `init_done` implies a non-zero type. `last_r1` holds the most recent R1. The reset state is: done 0, error 0, type 0, `spi_cs_n` 1, SCLK 0, MOSI 1.
- R11: Each SCLK high phase lasts exactly `CLK_DIV` clocks and SCLK rests low between bytes. MOSI changes only while SCLK is low, and MISO is sampled as SCLK rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Pulse to begin or restart the sequence |
| retry_max | input | RETRY_W | Maximum operating-condition attempts |
| spi_cs_n | output | 1 | Card chip select, active low |
| spi_sclk | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | Serial data to card |
| spi_miso | input | 1 | Serial data from card |
| init_done | output | 1 | Card is ready |
| init_error | output | 1 | Sequence failed |
| card_type | output | 2 | 0 none, 1 MMC, 2 SD v1, 3 SD v2 |
| high_cap | output | 1 | Block-addressed card |
| last_r1 | output | 8 | Most recent R1 byte |
| ocr | output | 32 | OCR read at the end |

## Verification
A behavioural card in the bench answers as an SD v2, SD v1, MMC or silent device, so each fallback branch and each type code is reached. Response latency is swept to 7 and 8 filler bytes, which separates a correct poll bound from an off-by-one. Post-response busy bytes show whether the flush waits for 0xFF. Idle-loop lengths equal to and one above `retry_max` pin down the retry limit for both the SD and MMC paths. A wrong interface-condition echo and an OCR with bit 30 set on a v1 card confirm the v2-only acceptance and capacity rules.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  typedef enum logic [1:0] {
    CARD_NONE = 2'd0,
    CARD_MMC  = 2'd1,
    CARD_SD1  = 2'd2,
    CARD_SD2  = 2'd3
  } card_kind_e;

  typedef enum logic [2:0] {
    SEL_RESET,
    SEL_IFCOND,
    SEL_APPPFX,
    SEL_OPCOND_SD,
    SEL_OPCOND_MMC,
    SEL_OCR
  } cmd_sel_e;

  localparam logic [7:0] R1_IDLE    = 8'h01;
  localparam int         R1_ILLEGAL = 2;
  localparam int         FRAME_LEN  = 6;
endpackage

// File: rtl/sdi_spi_byte.sv
module sdi_spi_byte #(
  parameter int CLK_DIV = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          active;
  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      div     <= '0;
      bitn    <= '0;
      sh      <= 8'hFF;
      rx_byte <= 8'hFF;
      sclk    <= 1'b0;
      mosi    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          sh     <= tx_byte;
          mosi   <= tx_byte[7];
          div    <= '0;
          bitn   <= '0;
        end
      end else if (div != DIV_LAST) begin
        div <= div + DW'(1);
      end else begin
        div <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
            mosi   <= 1'b1;
          end else begin
            bitn <= bitn + 3'd1;
            sh   <= {sh[6:0], 1'b1};
            mosi <= sh[6];
          end
        end
      end
    end
  end

  // R11: clock rests low outside a transfer
  p_sclk_rest_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk);
  // R11: data line holds while clock is high
  p_mosi_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
endmodule

// File: rtl/sdi_cmd_frame.sv
module sdi_cmd_frame
  import sdi_pkg::*;
(
  input  cmd_sel_e   sel,
  input  logic       hcs,
  input  logic [2:0] idx,
  output logic [7:0] tx_byte
);
  logic [47:0] frame;

  always_comb begin
    unique case (sel)
      SEL_RESET:      frame = {8'h40, 32'h0000_0000, 8'h95};
      SEL_IFCOND:     frame = {8'h48, 32'h0000_01AA, 8'h87};
      SEL_APPPFX:     frame = {8'h77, 32'h0000_0000, 8'h65};
      SEL_OPCOND_SD:  frame = hcs ? {8'h69, 32'h4010_0000, 8'hCD}
                                  : {8'h69, 32'h0010_0000, 8'h5F};
      SEL_OPCOND_MMC: frame = {8'h41, 32'h0000_0000, 8'hF9};
      SEL_OCR:        frame = {8'h7A, 32'h0000_0000, 8'hFD};
      default:        frame = {48{1'b1}};
    endcase
    case (idx)
      3'd0:    tx_byte = frame[47:40];
      3'd1:    tx_byte = frame[39:32];
      3'd2:    tx_byte = frame[31:24];
      3'd3:    tx_byte = frame[23:16];
      3'd4:    tx_byte = frame[15:8];
      3'd5:    tx_byte = frame[7:0];
      default: tx_byte = 8'hFF;
    endcase
  end
endmodule

// File: rtl/sdi_init_fsm.sv
module sdi_init_fsm
  import sdi_pkg::*;
#(
  parameter int WAKE_BYTES = 10,
  parameter int POLL_MAX   = 8,
  parameter int FLUSH_MAX  = 16,
  parameter int RETRY_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RETRY_W-1:0] retry_max,
  output logic               x_go,
  output logic [7:0]         x_tx,
  input  logic               x_done,
  input  logic [7:0]         x_rx,
  output cmd_sel_e           f_sel,
  output logic [2:0]         f_idx,
  output logic               f_hcs,
  input  logic [7:0]         f_byte,
  output logic               cs_n,
  output logic               done,
  output logic               error,
  output card_kind_e         ctype,
  output logic               hc,
  output logic [7:0]         r1,
  output logic [31:0]        ocr
);
  localparam int CMAX = (WAKE_BYTES > FLUSH_MAX) ?
                        ((WAKE_BYTES > POLL_MAX) ? WAKE_BYTES : POLL_MAX) :
                        ((FLUSH_MAX > POLL_MAX) ? FLUSH_MAX : POLL_MAX);
  localparam int CW = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAKE, ST_FLUSH, ST_SEND, ST_POLL, ST_TAIL, ST_EVAL, ST_DONE, ST_FAIL
  } st_e;

  st_e                state;
  logic [CW-1:0]      cnt;
  logic               pend;
  logic [31:0]        tail;
  logic [RETRY_W-1:0] retry;
  logic               last_try;
  logic               need_tail;

  assign x_tx      = (state == ST_SEND) ? f_byte : 8'hFF;
  assign f_idx     = cnt[2:0];
  assign f_hcs     = (ctype == CARD_SD2);
  assign last_try  = (retry + RETRY_W'(1)) >= retry_max;
  assign need_tail = ((f_sel == SEL_IFCOND) && !x_rx[R1_ILLEGAL]) || (f_sel == SEL_OCR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;  cnt   <= '0;        pend  <= 1'b0;  x_go <= 1'b0;
      cs_n  <= 1'b1;     f_sel <= SEL_RESET; ctype <= CARD_NONE;
      hc    <= 1'b0;     r1    <= 8'hFF;     ocr   <= '0;    tail <= '0;
      retry <= '0;       done  <= 1'b0;      error <= 1'b0;
    end else begin
      x_go <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE, ST_FAIL: begin
          if (start) begin
            state <= ST_WAKE;   cnt   <= '0;        cs_n  <= 1'b1;
            f_sel <= SEL_RESET; ctype <= CARD_NONE; hc    <= 1'b0;
            done  <= 1'b0;      error <= 1'b0;      retry <= '0;
            r1    <= 8'hFF;     ocr   <= '0;
          end
        end
        ST_EVAL: begin
          state <= ST_FLUSH;
          cnt   <= '0;
          unique case (f_sel)
            SEL_RESET:
              if (r1 == R1_IDLE) f_sel <= SEL_IFCOND;
              else begin state <= ST_FAIL; error <= 1'b1; end
            SEL_IFCOND:
              if (r1[R1_ILLEGAL]) begin ctype <= CARD_SD1; f_sel <= SEL_APPPFX; end
              else if (r1 != R1_IDLE || tail[11:0] != 12'h1AA) begin
                state <= ST_FAIL; error <= 1'b1;
              end else begin ctype <= CARD_SD2; f_sel <= SEL_APPPFX; end
            SEL_APPPFX: f_sel <= SEL_OPCOND_SD;
            SEL_OPCOND_SD:
              if (r1[R1_ILLEGAL]) begin
                ctype <= CARD_MMC; f_sel <= SEL_OPCOND_MMC; retry <= '0;
              end else if (r1 == 8'h00) f_sel <= SEL_OCR;
              else if (r1 == R1_IDLE && !last_try) begin
                retry <= retry + RETRY_W'(1); f_sel <= SEL_APPPFX;
              end else begin state <= ST_FAIL; error <= 1'b1; end
            SEL_OPCOND_MMC:
              if (r1 == 8'h00) f_sel <= SEL_OCR;
              else if (r1 == R1_IDLE && !last_try) retry <= retry + RETRY_W'(1);
              else begin state <= ST_FAIL; error <= 1'b1; end
            SEL_OCR: begin
              ocr   <= tail;
              hc    <= (ctype == CARD_SD2) && tail[30];
              done  <= 1'b1;
              state <= ST_DONE;
            end
            default: begin state <= ST_FAIL; error <= 1'b1; end
          endcase
        end
        default: begin
          if (!pend) begin
            x_go <= 1'b1;
            pend <= 1'b1;
          end else if (x_done) begin
            pend <= 1'b0;
            case (state)
              ST_WAKE:
                if (cnt == CW'(WAKE_BYTES - 1)) begin
                  cs_n <= 1'b0; state <= ST_FLUSH; cnt <= '0;
                end else cnt <= cnt + CW'(1);
              ST_FLUSH:
                if (x_rx == 8'hFF) begin state <= ST_SEND; cnt <= '0; end
                else if (cnt == CW'(FLUSH_MAX - 1)) begin state <= ST_FAIL; error <= 1'b1; end
                else cnt <= cnt + CW'(1);
              ST_SEND:
                if (cnt == CW'(FRAME_LEN - 1)) begin state <= ST_POLL; cnt <= '0; end
                else cnt <= cnt + CW'(1);
              ST_POLL:
                if (!x_rx[7]) begin
                  r1    <= x_rx;
                  cnt   <= '0;
                  state <= need_tail ? ST_TAIL : ST_EVAL;
                end else if (cnt == CW'(POLL_MAX - 1)) begin
                  state <= ST_FAIL; error <= 1'b1;
                end else cnt <= cnt + CW'(1);
              ST_TAIL: begin
                tail <= {tail[23:0], x_rx};
                if (cnt == CW'(3)) state <= ST_EVAL;
                else cnt <= cnt + CW'(1);
              end
              default: state <= ST_FAIL;
            endcase
          end
        end
      endcase
    end
  end

  // R10: outcome flags are exclusive
  p_outcome_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R10: a ready card always has a type
  p_type_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ctype != CARD_NONE));
  // R9: capacity flag only for v2 cards
  p_hc_v2_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hc |-> (ctype == CARD_SD2));
  // R3: response search never passes its bound
  p_poll_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_POLL) |-> (cnt < CW'(POLL_MAX)));
  // R1: card stays deselected during wake-up clocks
  p_wake_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE) |-> cs_n);
  // R8: attempt counter stays below the limit
  p_retry_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_max != '0) |-> (retry < retry_max));
endmodule

// File: rtl/sd_spi_init.sv
module sd_spi_init
  import sdi_pkg::*;
#(
  parameter int CLK_DIV    = 200,
  parameter int WAKE_BYTES = 10,
  parameter int POLL_MAX   = 8,
  parameter int FLUSH_MAX  = 16,
  parameter int RETRY_W    = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RETRY_W-1:0] retry_max,
  output logic               spi_cs_n,
  output logic               spi_sclk,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic               init_done,
  output logic               init_error,
  output logic [1:0]         card_type,
  output logic               high_cap,
  output logic [7:0]         last_r1,
  output logic [31:0]        ocr
);
  logic       x_go, x_done, f_hcs;
  logic [7:0] x_tx, x_rx, f_byte;
  logic [2:0] f_idx;
  cmd_sel_e   f_sel;
  card_kind_e ctype;

  assign card_type = ctype;

  sdi_spi_byte #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(x_go), .tx_byte(x_tx), .done(x_done),
    .rx_byte(x_rx), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
  );

  sdi_cmd_frame u_frame (
    .sel(f_sel), .hcs(f_hcs), .idx(f_idx), .tx_byte(f_byte)
  );

  sdi_init_fsm #(
    .WAKE_BYTES(WAKE_BYTES), .POLL_MAX(POLL_MAX),
    .FLUSH_MAX(FLUSH_MAX), .RETRY_W(RETRY_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .retry_max(retry_max),
    .x_go(x_go), .x_tx(x_tx), .x_done(x_done), .x_rx(x_rx),
    .f_sel(f_sel), .f_idx(f_idx), .f_hcs(f_hcs), .f_byte(f_byte),
    .cs_n(spi_cs_n), .done(init_done), .error(init_error), .ctype(ctype),
    .hc(high_cap), .r1(last_r1), .ocr(ocr)
  );
endmodule

// File: tb/test_sd_spi_init.sv
module test_sd_spi_init;
  localparam int CLK_DIV = 2;
  localparam int RW      = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0, start = 1'b0;
  logic [RW-1:0] retry_max = 16'd20;
  logic          spi_cs_n, spi_sclk, spi_mosi, spi_miso;
  logic          init_done, init_error, high_cap;
  logic [1:0]    card_type;
  logic [7:0]    last_r1;
  logic [31:0]   ocr;

  sd_spi_init #(.CLK_DIV(CLK_DIV), .RETRY_W(RW)) i_sd_spi_init (
    .clk(clk), .rst_n(rst_n), .start(start), .retry_max(retry_max),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .init_done(init_done), .init_error(init_error), .card_type(card_type),
    .high_cap(high_cap), .last_r1(last_r1), .ocr(ocr)
  );

  int n_cmp = 0, n_bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- card model ----------------
  int         m_kind, m_delay, m_busy, m_idle, m_attempt;
  logic [7:0] m_echo;
  logic       m_hc;
  logic [7:0] q [0:31];
  int         q_len, q_idx;
  logic [7:0] fr [0:5];
  int         fr_n;
  logic       in_frame;
  int         frame_err, flush_err;
  logic [7:0] rxs, sh, nxt;
  int         bitc;
  logic       load;

  assign spi_miso = sh[7];

  task automatic push(input logic [7:0] b);
    q[q_len] = b;
    q_len++;
  endtask

  function automatic logic [31:0] model_ocr(input logic hcb);
    return {1'b1, hcb, 30'h00FF8000};
  endfunction

  task automatic respond();
    logic [47:0] got, exp;
    logic [31:0] o;
    got = {fr[0], fr[1], fr[2], fr[3], fr[4], fr[5]};
    case (fr[0][5:0])
      6'd0:  exp = 48'h40_0000_0000_95;
      6'd8:  exp = 48'h48_0000_01AA_87;
      6'd55: exp = 48'h77_0000_0000_65;
      6'd41: exp = (m_kind == 3) ? 48'h69_4010_0000_CD : 48'h69_0010_0000_5F;
      6'd1:  exp = 48'h41_0000_0000_F9;
      6'd58: exp = 48'h7A_0000_0000_FD;
      default: exp = '0;
    endcase
    if (got != exp) frame_err++;
    q_len = 0; q_idx = 0;
    for (int i = 0; i < m_delay; i++) push(8'hFF);
    if (m_kind != 0) begin
      case (fr[0][5:0])
        6'd0: push(8'h01);
        6'd8: if (m_kind == 3) begin
                push(8'h01); push(8'h00); push(8'h00); push(8'h01); push(m_echo);
              end else push(8'h05);
        6'd55: push(8'h01);
        6'd41, 6'd1:
          if (m_kind == 1 && fr[0][5:0] == 6'd41) push(8'h05);
          else if (m_attempt < m_idle) begin push(8'h01); m_attempt++; end
          else push(8'h00);
        6'd58: begin
          o = model_ocr(m_hc);
          push(8'h00); push(o[31:24]); push(o[23:16]); push(o[15:8]); push(o[7:0]);
        end
        default: push(8'h04);
      endcase
      for (int i = 0; i < m_busy; i++) push(8'h3C);
    end
  endtask

  task automatic on_byte(input logic [7:0] b);
    if (in_frame) begin
      fr[fr_n] = b;
      fr_n++;
      if (fr_n == 6) begin in_frame = 1'b0; respond(); end
    end else if (b[7:6] == 2'b01) begin
      if (q_idx < q_len) flush_err++;
      in_frame = 1'b1; fr[0] = b; fr_n = 1;
    end
    if (q_idx < q_len) begin nxt = q[q_idx]; q_idx++; end
    else nxt = 8'hFF;
  endtask

  always @(posedge spi_sclk) if (!spi_cs_n) begin
    rxs = {rxs[6:0], spi_mosi};
    bitc++;
    if (bitc == 8) begin bitc = 0; on_byte(rxs); load = 1'b1; end
  end

  always @(negedge spi_sclk) if (!spi_cs_n) begin
    if (load) begin sh = nxt; load = 1'b0; end
    else sh = {sh[6:0], 1'b1};
  end

  // ---------------- pin monitors ----------------
  int   wake_clks, wake_mosi_low, cs_bounce, sclk_err, hi_run;
  logic sel_seen, cs_prev;

  always @(posedge spi_sclk) if (spi_cs_n) begin
    wake_clks++;
    if (!spi_mosi) wake_mosi_low++;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!spi_cs_n) sel_seen = 1'b1;
      if (sel_seen && spi_cs_n && !cs_prev) cs_bounce++;
      if (spi_sclk) hi_run++;
      else if (hi_run != 0) begin
        if (hi_run != CLK_DIV) sclk_err++;
        hi_run = 0;
      end
    end
    cs_prev = spi_cs_n;
  end

  task automatic model_reset();
    q_len = 0; q_idx = 0; fr_n = 0; in_frame = 1'b0; m_attempt = 0;
    frame_err = 0; flush_err = 0; rxs = 8'hFF; sh = 8'hFF; nxt = 8'hFF;
    bitc = 0; load = 1'b0; wake_clks = 0; wake_mosi_low = 0;
    cs_bounce = 0; sclk_err = 0; hi_run = 0; sel_seen = 1'b0; cs_prev = 1'b1;
  endtask

  task automatic launch_and_wait(output logic timed_out);
    int t;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    t = 0;
    while (!init_done && !init_error && t < 60000) begin @(negedge clk); t++; end
    timed_out = (t >= 60000);
  endtask

  typedef struct packed {
    logic [1:0] kind;   logic [3:0] delay; logic [3:0] busy; logic [7:0] idle;
    logic [7:0] echo;   logic hc;          logic [7:0] rmax;
    logic exp_err;      logic [1:0] exp_type; logic exp_hc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd3, 4'd0, 4'd0, 8'd3, 8'hAA, 1'b1, 8'd20, 1'b0, 2'd3, 1'b1},
    '{2'd3, 4'd2, 4'd3, 8'd0, 8'hAA, 1'b0, 8'd20, 1'b0, 2'd3, 1'b0},
    '{2'd2, 4'd1, 4'd1, 8'd2, 8'hAA, 1'b1, 8'd20, 1'b0, 2'd2, 1'b0},
    '{2'd1, 4'd0, 4'd2, 8'd4, 8'hAA, 1'b1, 8'd20, 1'b0, 2'd1, 1'b0},
    '{2'd3, 4'd0, 4'd0, 8'd0, 8'h55, 1'b0, 8'd20, 1'b1, 2'd0, 1'b0},
    '{2'd3, 4'd0, 4'd1, 8'd4, 8'hAA, 1'b0, 8'd5,  1'b0, 2'd3, 1'b0},
    '{2'd3, 4'd0, 4'd1, 8'd5, 8'hAA, 1'b0, 8'd5,  1'b1, 2'd0, 1'b0},
    '{2'd3, 4'd7, 4'd0, 8'd0, 8'hAA, 1'b1, 8'd20, 1'b0, 2'd3, 1'b1},
    '{2'd3, 4'd8, 4'd0, 8'd0, 8'hAA, 1'b0, 8'd20, 1'b1, 2'd0, 1'b0},
    '{2'd0, 4'd0, 4'd0, 8'd0, 8'hAA, 1'b0, 8'd20, 1'b1, 2'd0, 1'b0},
    '{2'd1, 4'd0, 4'd0, 8'd3, 8'hAA, 1'b0, 8'd3,  1'b1, 2'd0, 1'b0}
  };

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic to;
    model_reset();
    m_kind = 3; m_delay = 0; m_busy = 0; m_idle = 0; m_echo = 8'hAA; m_hc = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10 reset done",  init_done, 0);
    chk("R10 reset error", init_error, 0);
    chk("R10 reset type",  card_type, 0);
    chk("R10 reset cs_n",  spi_cs_n, 1);
    chk("R10 reset sclk",  spi_sclk, 0);
    chk("R10 reset mosi",  spi_mosi, 1);

    for (int v = 0; v < NV; v++) begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      model_reset();
      m_kind = VECS[v].kind;  m_delay = VECS[v].delay; m_busy = VECS[v].busy;
      m_idle = VECS[v].idle;  m_echo = VECS[v].echo;   m_hc = VECS[v].hc;
      retry_max = RW'(VECS[v].rmax);
      rst_n = 1'b1;
      @(negedge clk);
      launch_and_wait(to);
      chk("R8 case finished in time", to, 0);
      // R3 R5 R8 outcome
      chk("R3/R5/R8 error flag", init_error, VECS[v].exp_err);
      chk("R10 done flag", init_done, !VECS[v].exp_err);
      if (!VECS[v].exp_err) begin
        chk("R6/R7 card type", card_type, VECS[v].exp_type);
        chk("R9 high capacity", high_cap, VECS[v].exp_hc);
        chk("R9 ocr value", ocr, model_ocr(VECS[v].hc));
        chk("R10 last r1", last_r1, 8'h00);
      end
      chk("R2/R5/R6/R7/R9 frame bytes", frame_err, 0);
      chk("R4 flush before frame", flush_err, 0);
      chk("R1 wake clocks >= 80", wake_clks >= 80, 1);
      chk("R1 wake mosi high", wake_mosi_low, 0);
      chk("R1 select held low", cs_bounce, 0);
      chk("R11 sclk high phase", sclk_err, 0);
    end

    // R1 R10: restart with start alone, no reset
    model_reset();
    m_kind = 2; m_delay = 0; m_busy = 0; m_idle = 1; m_hc = 1'b0;
    retry_max = 16'd20;
    launch_and_wait(to);
    chk("R1 restart finished", init_done, 1);
    chk("R1 restart wake clocks", wake_clks >= 80, 1);
    chk("R10 restart type", card_type, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule